// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel. It copies words from a contiguous source region into a series of destination blocks. A chain of descriptors held in memory describes those blocks. Before each block the channel reads a four-word descriptor from memory, one word at a time, in this order: a source word, the destination address, the next-descriptor pointer and a control word. The source word is read and then thrown away. The source address keeps counting from where the previous block stopped, so only the destination follows the list. The channel copies the block one transaction at a time. A transaction is one beat (single) or a burst of beats. Each transaction starts only when both endpoints are ready.

Both the descriptor traffic and the data traffic use one 32-bit memory port. That port follows a request/grant/response protocol. At the end of each block the channel writes the control word back into the descriptor with its done flag set. It then either follows the chain or stops. Sticky status bits record transaction, block, transfer and error events. Software clears them by writing ones, and a mask selects which of them drive the interrupt line.

Top module: `ll_dma_channel`

## Requirements
- R1: A one-cycle `ch_en_wr` pulse starts an idle channel only if `glb_en` is 1. A pulse while `glb_en` is 0 leaves the channel idle and makes no memory request. Once started, the channel reads the words at `cfg_init_ptr`, +4, +8 and +12, in that order.
- R2: The source word of every descriptor (offset 0) is never used as an address. The source reads begin at `cfg_src_base` and step by +4 per beat across all blocks of a run.
- R3: Control bits [19:18] select the destination stepping after each beat: 0 steps +4, 1 steps −4, and 2 or 3 keep the address fixed. Each block starts at the destination word of its descriptor (offset 4).
- R4: The channel fetches the descriptor at the next pointer (offset 8) when control bit 20 is 1 and that pointer is non-zero. Otherwise it stops after the block, sets status bit 0 (transfer complete) and goes idle.
- R5: When a block ends, the channel writes the fetched control word with bit 31 (done) set to descriptor offset 12, then sets status bit 1 (block complete).
- R6: Each transaction waits until both directions are ready. A direction is always ready when its memory flag is 1. Otherwise its select bit chooses the line: 0 uses the hardware request line and 1 uses the software request line. The line that is not selected has no effect.
- R7: A block holds control[15:0] transactions. Control bits [17:16] set the beats per transaction: 0 is one beat, 1 is 4, 2 is 8 and 3 is 16. At the end of each transaction `src_ack` and `dst_ack` both pulse for one cycle, and status bits 2 (source transaction) and 3 (destination transaction) are set.
- R8: Writing a 1 on an `st_clr` bit clears that status bit, and a set in the same cycle wins. `irq` is high when any status bit is set whose `st_mask` bit is 1.
- R9: An error response to any access sends the channel idle at once and sets status bit 4. The channel makes no further requests, and the done write-back of that block is skipped.
- R10: A memory request holds its address, direction and write data stable until it is granted. At most one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global controller enable |
| ch_en_wr | input | 1 | Pulse: write 1 to the channel enable |
| cfg_init_ptr | input | AW | Address of the first descriptor |
| cfg_src_base | input | AW | First source address |
| cfg_src_hs_sw | input | 1 | Source request select: 0 hardware, 1 software |
| cfg_dst_hs_sw | input | 1 | Destination request select: 0 hardware, 1 software |
| cfg_src_mem | input | 1 | Source is memory, so no handshake |
| cfg_dst_mem | input | 1 | Destination is memory, so no handshake |
| hw_src_req | input | 1 | Hardware source request line |
| hw_dst_req | input | 1 | Hardware destination request line |
| sw_src_req | input | 1 | Software source request |
| sw_dst_req | input | 1 | Software destination request |
| src_ack | output | 1 | Source transaction acknowledge pulse |
| dst_ack | output | 1 | Destination transaction acknowledge pulse |
| st_clr | input | 5 | Write-one-to-clear strobes for the status bits |
| st_mask | input | 5 | Interrupt mask for the status bits |
| status | output | 5 | Status: 0 transfer, 1 block, 2 source txn, 3 dest txn, 4 error |
| irq | output | 1 | Masked interrupt |
| busy | output | 1 | Channel active |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Response for the accepted access |
| mem_rdata | input | 32 | Read data with the response |
| mem_err | input | 1 | Error flag with the response |

## Verification
Several properties are checked on every cycle: a request that is not yet granted stays stable, and an idle channel makes no requests and gives no acknowledges. The checks also cover that a start attempt without the global enable does nothing, that an acknowledge comes with both transaction status bits, and that an error response stops the channel with the error bit set. Other behaviour can only be shown by the bench's scenarios. That covers where the data lands and the order of descriptor reads. It also covers the source continuing across blocks while the descriptor source words are ignored, each destination stepping mode, the done write-back, the request-select behaviour and partial status clears.

// File: rtl/llch_pkg.sv
package llch_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_RD,
    S_WR,
    S_WB
  } llch_state_e;

  localparam int DW         = 32;
  localparam int LEN_W      = 16;
  localparam int LEN_LSB    = 0;
  localparam int BURST_LSB  = 16;
  localparam int DMODE_LSB  = 18;
  localparam int LINK_BIT   = 20;
  localparam int DONE_BIT   = 31;
  localparam int BEAT_W     = 5;

  localparam int NST        = 5;
  localparam int ST_XFER    = 0;
  localparam int ST_BLK     = 1;
  localparam int ST_STRAN   = 2;
  localparam int ST_DTRAN   = 3;
  localparam int ST_ERR     = 4;

  function automatic logic [BEAT_W-1:0] beats_of(input logic [1:0] code);
    case (code)
      2'd0:    beats_of = BEAT_W'(1);
      2'd1:    beats_of = BEAT_W'(4);
      2'd2:    beats_of = BEAT_W'(8);
      default: beats_of = BEAT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/llch_hs.sv
module llch_hs (
  input  logic sel_sw,
  input  logic is_mem,
  input  logic hw_req,
  input  logic sw_req,
  output logic ready
);
  always_comb begin
    if (is_mem) ready = 1'b1;
    else        ready = sel_sw ? sw_req : hw_req;
  end
endmodule

// File: rtl/llch_addr.sv
module llch_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_load,
  input  logic [AW-1:0] src_init,
  input  logic          src_adv,
  input  logic          dst_load,
  input  logic [AW-1:0] dst_init,
  input  logic          dst_adv,
  input  logic [1:0]    dmode,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  localparam logic [AW-1:0] WSTEP = AW'(4);

  logic [AW-1:0] src_d, dst_d;

  always_comb begin
    src_d = src_addr;
    if (src_load)     src_d = src_init;
    else if (src_adv) src_d = src_addr + WSTEP;
  end

  always_comb begin
    dst_d = dst_addr;
    if (dst_load) begin
      dst_d = dst_init;
    end else if (dst_adv) begin
      case (dmode)
        2'd0:    dst_d = dst_addr + WSTEP;
        2'd1:    dst_d = dst_addr - WSTEP;
        default: dst_d = dst_addr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
    end else begin
      if (src_load || src_adv) src_addr <= src_d;
      if (dst_load || dst_adv) dst_addr <= dst_d;
    end
  end
endmodule

// File: rtl/llch_status.sv
module llch_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] status_d;

  always_comb status_d = (status & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/ll_dma_channel.sv
module ll_dma_channel
  import llch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              ch_en_wr,
  input  logic [AW-1:0]     cfg_init_ptr,
  input  logic [AW-1:0]     cfg_src_base,
  input  logic              cfg_src_hs_sw,
  input  logic              cfg_dst_hs_sw,
  input  logic              cfg_src_mem,
  input  logic              cfg_dst_mem,
  input  logic              hw_src_req,
  input  logic              hw_dst_req,
  input  logic              sw_src_req,
  input  logic              sw_dst_req,
  output logic              src_ack,
  output logic              dst_ack,
  input  logic [NST-1:0]    st_clr,
  input  logic [NST-1:0]    st_mask,
  output logic [NST-1:0]    status,
  output logic              irq,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_err
);
  localparam logic [AW-1:0] CTL_OFS = AW'(12);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  // handshake qualification, one per direction (0 = source, 1 = destination)
  logic [1:0] hs_sw, is_mem, hw_req, sw_req, dir_ok;
  assign hs_sw  = {cfg_dst_hs_sw, cfg_src_hs_sw};
  assign is_mem = {cfg_dst_mem,   cfg_src_mem};
  assign hw_req = {hw_dst_req,    hw_src_req};
  assign sw_req = {sw_dst_req,    sw_src_req};

  for (genvar d = 0; d < 2; d++) begin : g_hs
    llch_hs u_hs (
      .sel_sw (hs_sw[d]),
      .is_mem (is_mem[d]),
      .hw_req (hw_req[d]),
      .sw_req (sw_req[d]),
      .ready  (dir_ok[d])
    );
  end

  // channel state
  llch_state_e       st, st_d;
  logic              pend, pend_d;
  logic [1:0]        widx, widx_d;
  logic [AW-1:0]     dptr, dptr_d;
  logic [AW-1:0]     nptr, nptr_d;
  logic [DW-1:0]     ctl, ctl_d;
  logic [BEAT_W-1:0] beat, beat_d;
  logic [LEN_W-1:0]  txn, txn_d;
  logic [DW-1:0]     dbuf, dbuf_d;
  logic              ack_d, ack_q;

  logic              src_load, src_adv, dst_load, dst_adv;
  logic [AW-1:0]     src_addr, dst_addr;
  logic [NST-1:0]    st_set;

  logic              acc;
  logic              accept, resp, rerr;
  logic [BEAT_W-1:0] nbeats;
  logic [LEN_W-1:0]  blk_len;
  logic              last_beat, last_txn, chain_on;

  assign nbeats    = beats_of(ctl[BURST_LSB +: 2]);
  assign blk_len   = ctl[LEN_LSB +: LEN_W];
  assign last_beat = (beat == nbeats - BEAT_W'(1));
  assign last_txn  = ((txn + LEN_W'(1)) >= blk_len);
  assign chain_on  = ctl[LINK_BIT] && (nptr != '0);

  // memory port
  always_comb begin
    acc       = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_FETCH: begin
        acc      = 1'b1;
        mem_addr = dptr + {{(AW-4){1'b0}}, widx, 2'b00};
      end
      S_RD: begin
        acc      = 1'b1;
        mem_addr = src_addr;
      end
      S_WR: begin
        acc       = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_addr;
        mem_wdata = dbuf;
      end
      S_WB: begin
        acc       = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dptr + CTL_OFS;
        mem_wdata = ctl | (DW'(1) << DONE_BIT);
      end
      default: ;
    endcase
  end

  assign mem_req = acc && !pend;
  assign accept  = mem_req && mem_gnt;
  assign resp    = pend && mem_rvalid;
  assign rerr    = resp && mem_err;

  // next-state logic
  always_comb begin
    st_d     = st;
    pend_d   = pend;
    widx_d   = widx;
    dptr_d   = dptr;
    nptr_d   = nptr;
    ctl_d    = ctl;
    beat_d   = beat;
    txn_d    = txn;
    dbuf_d   = dbuf;
    ack_d    = 1'b0;
    src_load = 1'b0;
    src_adv  = 1'b0;
    dst_load = 1'b0;
    dst_adv  = 1'b0;
    st_set   = '0;

    if (accept) pend_d = 1'b1;
    if (resp)   pend_d = 1'b0;

    if (rerr) begin
      st_d           = S_IDLE;
      st_set[ST_ERR] = 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (ch_en_wr && glb_en) begin
            dptr_d   = cfg_init_ptr;
            widx_d   = 2'd0;
            src_load = 1'b1;
            st_d     = S_FETCH;
          end
        end
        S_FETCH: begin
          if (resp) begin
            widx_d = widx + 2'd1;
            case (widx)
              2'd1:    dst_load = 1'b1;
              2'd2:    nptr_d   = mem_rdata;
              2'd3: begin
                ctl_d  = mem_rdata;
                beat_d = '0;
                txn_d  = '0;
                st_d   = S_WAIT;
              end
              default: ; // source word: read, not used
            endcase
          end
        end
        S_WAIT: begin
          if (&dir_ok) st_d = S_RD;
        end
        S_RD: begin
          if (resp) begin
            dbuf_d  = mem_rdata;
            src_adv = 1'b1;
            st_d    = S_WR;
          end
        end
        S_WR: begin
          if (resp) begin
            dst_adv = 1'b1;
            if (last_beat) begin
              beat_d           = '0;
              ack_d            = 1'b1;
              st_set[ST_STRAN] = 1'b1;
              st_set[ST_DTRAN] = 1'b1;
              if (last_txn) begin
                st_d = S_WB;
              end else begin
                txn_d = txn + LEN_W'(1);
                st_d  = S_WAIT;
              end
            end else begin
              beat_d = beat + BEAT_W'(1);
              st_d   = S_RD;
            end
          end
        end
        S_WB: begin
          if (resp) begin
            st_set[ST_BLK] = 1'b1;
            if (chain_on) begin
              dptr_d = nptr;
              widx_d = 2'd0;
              st_d   = S_FETCH;
            end else begin
              st_set[ST_XFER] = 1'b1;
              st_d            = S_IDLE;
            end
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pend  <= 1'b0;
      widx  <= '0;
      dptr  <= '0;
      nptr  <= '0;
      ctl   <= '0;
      beat  <= '0;
      txn   <= '0;
      dbuf  <= '0;
      ack_q <= 1'b0;
    end else if (rst_i) begin
      st    <= st_d;
      pend  <= pend_d;
      widx  <= widx_d;
      dptr  <= dptr_d;
      nptr  <= nptr_d;
      ctl   <= ctl_d;
      beat  <= beat_d;
      txn   <= txn_d;
      dbuf  <= dbuf_d;
      ack_q <= ack_d;
    end
  end

  llch_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_load (src_load),
    .src_init (cfg_src_base),
    .src_adv  (src_adv),
    .dst_load (dst_load),
    .dst_init (mem_rdata[AW-1:0]),
    .dst_adv  (dst_adv),
    .dmode    (ctl[DMODE_LSB +: 2]),
    .src_addr (src_addr),
    .dst_addr (dst_addr)
  );

  llch_status #(.N(NST)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (st_set),
    .clr    (st_clr),
    .mask   (st_mask),
    .status (status),
    .irq    (irq)
  );

  assign busy    = (st != S_IDLE);
  assign src_ack = ack_q;
  assign dst_ack = ack_q;

endmodule

// File: rtl/ll_dma_channel_chk.sv
module ll_dma_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en,
  input logic          busy,
  input logic          src_ack,
  input logic          dst_ack,
  input logic [4:0]    status,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_gnt,
  input logic          mem_rvalid,
  input logic          mem_err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !src_ack && !dst_ack)); // R9

  AST_NO_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !glb_en) |=> !busy); // R1

  AST_ACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack |-> (dst_ack && status[2] && status[3])); // R7

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rvalid && mem_err) |=> (!busy && status[4])); // R9
endmodule

bind ll_dma_channel ll_dma_channel_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glb_en     (glb_en),
  .busy       (busy),
  .src_ack    (src_ack),
  .dst_ack    (dst_ack),
  .status     (status),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_gnt    (mem_gnt),
  .mem_rvalid (mem_rvalid),
  .mem_err    (mem_err)
);

// File: tb/ll_dma_channel_test.sv
`timescale 1ns/1ps
module ll_dma_channel_test;
  localparam int AW = 32;

  logic        clk, rst_n;
  logic        glb_en, ch_en_wr;
  logic [31:0] cfg_init_ptr, cfg_src_base;
  logic        cfg_src_hs_sw, cfg_dst_hs_sw, cfg_src_mem, cfg_dst_mem;
  logic        hw_src_req, hw_dst_req, sw_src_req, sw_dst_req;
  logic        src_ack, dst_ack;
  logic [4:0]  st_clr, st_mask, status;
  logic        irq, busy;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  ll_dma_channel #(.AW(AW)) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- memory model ----------------
  logic [31:0] mem [0:511];
  logic [31:0] log_addr [0:255];
  logic        log_we   [0:255];
  int          log_n;
  logic        gnt_en;
  logic [1:0]  lat;
  logic [31:0] resp_data;
  logic        resp_err;
  logic [31:0] err_addr;
  logic        err_on;
  int          ack_cnt;
  int          cyc;
  int          checks, failures;
  logic        rand_hs;

  assign mem_gnt   = gnt_en && (lat == 2'd0) && !mem_rvalid;
  assign mem_rdata = resp_data;
  assign mem_err   = resp_err;

  always @(posedge clk) begin
    gnt_en <= ($urandom % 3) != 0;
    if (!rst_n) begin
      lat        <= 2'd0;
      mem_rvalid <= 1'b0;
      resp_data  <= '0;
      resp_err   <= 1'b0;
    end else begin
      mem_rvalid <= (lat == 2'd1);
      if (lat != 2'd0) lat <= lat - 2'd1;
      if (mem_req && mem_gnt) begin
        lat <= 2'd1 + 2'($urandom % 2);
        resp_err <= err_on && (mem_addr == err_addr);
        if (mem_we) begin
          if (!(err_on && mem_addr == err_addr)) mem[mem_addr[10:2]] <= mem_wdata;
          resp_data <= '0;
        end else begin
          resp_data <= mem[mem_addr[10:2]];
        end
        if (log_n < 256) begin
          log_addr[log_n] <= mem_addr;
          log_we[log_n]   <= mem_we;
        end
        log_n <= log_n + 1;
      end
      if (src_ack) ack_cnt <= ack_cnt + 1;
    end
  end

  // random request lines for the handshaked run
  always @(negedge clk) begin
    if (rand_hs) begin
      hw_src_req <= ($urandom % 2) != 0;
      sw_dst_req <= ($urandom % 2) != 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input int len, input int bcode, input int dmode, input bit link);
    return 32'(len) | (32'(bcode) << 16) | (32'(dmode) << 18) | (32'(link) << 20);
  endfunction

  function automatic logic [31:0] sentinel(input int idx);
    return 32'hA5A5_0000 | 32'(idx);
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a[10:2]] = v;
  endtask

  function automatic logic [31:0] get(input logic [31:0] a);
    return mem[a[10:2]];
  endfunction

  task automatic start_ch();
    @(negedge clk); ch_en_wr = 1'b1;
    @(negedge clk); ch_en_wr = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); st_clr = 5'h1F;
    @(negedge clk); st_clr = 5'h00;
  endtask

  task automatic wait_idle(input int max, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (!busy) begin ok = 1'b1; break; end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  logic [31:0] srcv [0:15];
  logic [31:0] ctl_a, ctl_b, ctl_c, ctl_d;

  initial begin
    bit ok;
    int n0;
    int k;
    logic [31:0] nexp;
    bit bad;
    void'($urandom(32'd2718));
    checks = 0; failures = 0; cyc = 0; ack_cnt = 0; log_n = 0;
    rst_n = 1'b0; glb_en = 1'b0; ch_en_wr = 1'b0;
    cfg_init_ptr = '0; cfg_src_base = '0;
    cfg_src_hs_sw = 1'b0; cfg_dst_hs_sw = 1'b1; cfg_src_mem = 1'b0; cfg_dst_mem = 1'b0;
    hw_src_req = 1'b0; hw_dst_req = 1'b1; sw_src_req = 1'b1; sw_dst_req = 1'b0;
    st_clr = '0; st_mask = '0; err_on = 1'b0; err_addr = '0; rand_hs = 1'b0;
    for (int i = 0; i < 512; i++) mem[i] = sentinel(i);
    repeat (3) @(negedge clk);

    // reset state
    chk("R1", "reset busy", {31'b0, busy}, 32'd0);
    chk("R8", "reset status", {27'b0, status}, 32'd0);
    chk("R10", "reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: start attempt with global enable low is ignored
    cfg_init_ptr = 32'h100;
    start_ch();
    repeat (20) @(negedge clk);
    chk("R1", "gated start busy", {31'b0, busy}, 32'd0);
    chk("R1", "gated start no access", 32'(log_n), 32'd0);

    // two-descriptor chain: A (inc, 2 x burst4, linked) -> B (dec, 3 singles, last)
    for (int i = 0; i < 11; i++) begin
      srcv[i] = $urandom;
      put(32'h400 + 32'(4*i), srcv[i]);
    end
    ctl_a = mk_ctl(2, 1, 0, 1'b1);
    ctl_b = mk_ctl(3, 0, 1, 1'b0);
    put(32'h100, 32'h480); put(32'h104, 32'h200); put(32'h108, 32'h140); put(32'h10C, ctl_a);
    put(32'h140, 32'h4C0); put(32'h144, 32'h2FC); put(32'h148, 32'h0);   put(32'h14C, ctl_b);
    cfg_src_base = 32'h400;
    glb_en = 1'b1;
    start_ch();
    repeat (80) @(negedge clk);
    // R6: selected lines low, unselected lines high -> no transaction yet
    chk("R6", "held busy", {31'b0, busy}, 32'd1);
    chk("R6", "held no ack", 32'(ack_cnt), 32'd0);
    chk("R6", "held dst untouched", get(32'h200), sentinel(32'h200 >> 2));
    chk("R1", "fetch word0 addr", log_addr[0], 32'h100);
    chk("R1", "fetch word1 addr", log_addr[1], 32'h104);
    chk("R1", "fetch word2 addr", log_addr[2], 32'h108);
    chk("R1", "fetch word3 addr", log_addr[3], 32'h10C);
    rand_hs = 1'b1;
    wait_idle(20000, ok);
    rand_hs = 1'b0;
    chk("R4", "chain finished", {31'b0, ok}, 32'd1);
    for (int i = 0; i < 8; i++)
      chk("R3", "inc block word", get(32'h200 + 32'(4*i)), srcv[i]);
    chk("R3", "inc block end sentinel", get(32'h220), sentinel(32'h220 >> 2));
    for (int i = 0; i < 3; i++)
      chk("R2", "dec block word", get(32'h2FC - 32'(4*i)), srcv[8+i]);
    chk("R3", "dec block end sentinel", get(32'h2F0), sentinel(32'h2F0 >> 2));
    chk("R5", "done A", get(32'h10C), ctl_a | 32'h8000_0000);
    chk("R5", "done B", get(32'h14C), ctl_b | 32'h8000_0000);
    chk("R7", "transaction acks", 32'(ack_cnt), 32'd5);
    chk("R4", "status after chain", {27'b0, status}, 32'h0F);
    // R2: source reads contiguous, junk descriptor source words never read
    k = 0; bad = 1'b0; nexp = 32'h400;
    for (int i = 0; i < log_n && i < 256; i++) begin
      if (!log_we[i] && log_addr[i] >= 32'h400 && log_addr[i] < 32'h600) begin
        if (log_addr[i] != nexp) bad = 1'b1;
        nexp = nexp + 32'd4;
        k++;
      end
    end
    chk("R2", "source read count", 32'(k), 32'd11);
    chk("R2", "source reads contiguous", {31'b0, bad}, 32'd0);

    // R8: partial W1C clear and mask
    @(negedge clk); st_clr = 5'b00110;
    @(negedge clk); st_clr = 5'b00000;
    chk("R8", "partial clear", {27'b0, status}, 32'h09);
    st_mask = 5'b00110;
    @(negedge clk);
    chk("R8", "irq masked off", {31'b0, irq}, 32'd0);
    st_mask = 5'b00001;
    @(negedge clk);
    chk("R8", "irq masked on", {31'b0, irq}, 32'd1);
    clear_all();
    chk("R8", "clear all", {27'b0, status}, 32'd0);

    // fixed destination, memory endpoints, link bit off with non-zero pointer
    for (int i = 0; i < 8; i++) begin
      srcv[i] = $urandom;
      put(32'h500 + 32'(4*i), srcv[i]);
    end
    ctl_c = mk_ctl(2, 1, 2, 1'b0);
    put(32'h180, 32'h4E0); put(32'h184, 32'h300); put(32'h188, 32'h1C0); put(32'h18C, ctl_c);
    cfg_src_mem = 1'b1; cfg_dst_mem = 1'b1;
    hw_src_req = 1'b0; sw_src_req = 1'b0; hw_dst_req = 1'b0; sw_dst_req = 1'b0;
    cfg_init_ptr = 32'h180; cfg_src_base = 32'h500;
    n0 = log_n;
    start_ch();
    wait_idle(20000, ok);
    chk("R6", "memory endpoints need no request", {31'b0, ok}, 32'd1);
    chk("R3", "fixed dst last value", get(32'h300), srcv[7]);
    chk("R3", "fixed dst neighbour", get(32'h304), sentinel(32'h304 >> 2));
    chk("R4", "link off stops", 32'(log_n - n0), 32'd4 + 32'd16 + 32'd1);
    chk("R5", "done C", get(32'h18C), ctl_c | 32'h8000_0000);
    chk("R7", "status fixed run", {27'b0, status}, 32'h0F);
    clear_all();

    // error on third source read
    for (int i = 0; i < 4; i++) put(32'h580 + 32'(4*i), $urandom);
    ctl_d = mk_ctl(4, 0, 0, 1'b0);
    put(32'h1C0, 32'h0); put(32'h1C4, 32'h340); put(32'h1C8, 32'h0); put(32'h1CC, ctl_d);
    cfg_init_ptr = 32'h1C0; cfg_src_base = 32'h580;
    err_addr = 32'h588; err_on = 1'b1;
    start_ch();
    wait_idle(20000, ok);
    n0 = log_n;
    repeat (30) @(negedge clk);
    chk("R9", "error stops channel", {31'b0, busy}, 32'd0);
    chk("R9", "no requests after error", 32'(log_n - n0), 32'd0);
    chk("R9", "status after error", {27'b0, status}, 32'h1C);
    chk("R9", "dst word 1", get(32'h344), get(32'h584));
    chk("R9", "dst word 2 untouched", get(32'h348), sentinel(32'h348 >> 2));
    chk("R9", "no done write-back", get(32'h1CC), ctl_d);
    err_on = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule